// File: doc/BRIEF.md
# Memory-Mapped SD Sector Cache

This block lets a small processor treat one SD card sector as ordinary memory. It is a bus slave with a 16-bit word address, 32-bit write data, a write strobe and 32-bit read data. Behind that bus sit a 512-byte cache, a sector number register, two trigger locations and a few status words. Software writes the sector number and writes to the load trigger. It then polls the ready word and works on the cache in place. To push the modified cache back to the card, it writes to the flush trigger and polls again.

Towards the card the block drives an SD block controller. That side has a sector number, one-cycle start pulses for reading and writing, and a controller-idle input. Sector bytes move on two 8-bit valid/ready streams. On both streams a byte moves on a clock edge where valid and ready are both high. On the receive stream the block raises ready only while a load is in progress, and the controller may insert gaps by dropping valid. On the transmit stream the block raises valid only while a flush is in progress. Once valid is high, the block holds valid and the data unchanged until the controller accepts the byte, so the controller may stall for as long as it needs. The active-low card-detect input and the write-protect input are offered to software as status words.

Top module: `sd_sector_window`

## Requirements
- R1: Addresses 0x0000 to 0x01FC reach cache word addr[8:2]. Address bits 1:0 are ignored. A host write stores the 32-bit word. Read data for any address appears on `host_rdata` in the cycle after the address is presented.
- R2: Address 0x1000 holds the sector number, which is readable and writable. `card_sector` always drives its value. It resets to 0.
- R3: Writing any value to 0x1004 while ready starts a load. The block waits for `card_ready`, then pulses `rd_start` for exactly one cycle. It then accepts 512 bytes on the receive stream. Stream byte 4k lands in bits 7:0 of cache word k and byte 4k+3 in bits 31:24.
- R4: Writing any value to 0x1008 while ready starts a flush. The block waits for `card_ready`, then pulses `wr_start` for exactly one cycle. It then sends the 512 cache bytes in the same little-endian order. `tx_valid` and `tx_data` stay unchanged until `tx_ready` is high.
- R5: A read of 0x2000 returns `card_detect_n` in bit 0. A read of 0x2004 returns `write_prot` in bit 0. All other bits are 0.
- R6: A read of 0x2010 returns 1 when no transfer is running. It returns 0 from the cycle after an accepted trigger until the last byte has moved. The block is idle again in the cycle after the last byte.
- R7: A read of 0x2014 returns the dirty flag. Any accepted host write into the cache sets it. The completion of a load or of a flush clears it.
- R8: While a transfer runs, the block ignores host writes to the triggers, to the sector register and to the cache.
- R9: Reads of unmapped addresses return 0. Reads of the cache window during a transfer return 0.
- R10: After reset the block is ready and clean, with sector 0. `rd_start`, `wr_start`, `rx_ready` and `tx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 32 | Read data, one cycle after the address |
| card_detect_n | input | 1 | Card present, active low |
| write_prot | input | 1 | Card write-protect switch |
| card_ready | input | 1 | Block controller idle and able to start |
| card_sector | output | 32 | Sector number for the controller |
| rd_start | output | 1 | One-cycle start of a sector read |
| wr_start | output | 1 | One-cycle start of a sector write |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Controller accepts a transmit byte |
| tx_data | output | 8 | Transmit byte |

## Verification
Assertions check four rules on every cycle: transmit valid and data stay stable under back-pressure; the dirty flag follows cache writes and transfer completion; the sector number stays frozen while a transfer runs; and the engine is idle right after its last byte. Only the bench scenarios can show the rest. That covers the little-endian byte order in both directions, payload integrity under random stream gaps, the single-cycle start pulses that wait for the controller, and the fact that triggers, sector writes and cache writes during a transfer leave no trace. It also covers the zero values returned by unmapped or blocked reads.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [15:0] MAP_SECTOR = 16'h1000;
  localparam logic [15:0] MAP_LOAD   = 16'h1004;
  localparam logic [15:0] MAP_FLUSH  = 16'h1008;
  localparam logic [15:0] MAP_DETECT = 16'h2000;
  localparam logic [15:0] MAP_WPROT  = 16'h2004;
  localparam logic [15:0] MAP_READY  = 16'h2010;
  localparam logic [15:0] MAP_DIRTY  = 16'h2014;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_RD_ARM,
    ENG_RD_DATA,
    ENG_WR_ARM,
    ENG_WR_FETCH,
    ENG_WR_DATA
  } eng_state_t;
endpackage

// File: rtl/sdw_cache_ram.sv
module sdw_cache_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single port, read-before-write, suited to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/sdw_xfer_engine.sv
module sdw_xfer_engine
  import sdw_pkg::*;
#(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BPW    = WORD_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(BPW),
  localparam int unsigned BYTES  = WORDS * BPW,
  localparam int unsigned BCNT_W = $clog2(BYTES),
  localparam int unsigned WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_go,
  input  logic              flush_go,
  output logic              idle,
  output logic              done,
  output logic [WIDX_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_q,
  input  logic              card_ready,
  output logic              rd_start,
  output logic              wr_start,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data
);
  eng_state_t        state_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [BYTE_W-1:0] pack_q [BPW-1];
  logic [LANE_W-1:0] lane;
  logic              last_byte, last_lane, rx_fire, tx_fire;

  assign lane      = bcnt_q[LANE_W-1:0];
  assign last_byte = (bcnt_q == BCNT_W'(BYTES - 1));
  assign last_lane = (lane == LANE_W'(BPW - 1));

  always_comb begin
    idle     = (state_q == ENG_IDLE);
    rd_start = (state_q == ENG_RD_ARM) && card_ready;
    wr_start = (state_q == ENG_WR_ARM) && card_ready;
    rx_ready = (state_q == ENG_RD_DATA);
    tx_valid = (state_q == ENG_WR_DATA);
    tx_data  = ram_q[BYTE_W*lane +: BYTE_W];
    rx_fire  = rx_valid && rx_ready;
    tx_fire  = tx_valid && tx_ready;
    done     = (rx_fire || tx_fire) && last_byte;
    ram_addr = bcnt_q[BCNT_W-1:LANE_W];
    ram_we   = rx_fire && last_lane;
  end

  // word assembly: lower lanes from the holding bytes, top lane live
  always_comb begin
    for (int b = 0; b < BPW - 1; b++) ram_wdata[BYTE_W*b +: BYTE_W] = pack_q[b];
    ram_wdata[WORD_W-1 -: BYTE_W] = rx_data;
  end

  for (genvar g = 0; g < BPW - 1; g++) begin : g_pack
    always_ff @(posedge clk) begin
      if (!rst_n) pack_q[g] <= '0;
      else if (rx_fire && lane == LANE_W'(g)) pack_q[g] <= rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      bcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          bcnt_q <= '0;
          if (load_go)       state_q <= ENG_RD_ARM;
          else if (flush_go) state_q <= ENG_WR_ARM;
        end
        ENG_RD_ARM:   if (card_ready) state_q <= ENG_RD_DATA;
        ENG_RD_DATA: if (rx_fire) begin
          bcnt_q <= bcnt_q + BCNT_W'(1);
          if (last_byte) state_q <= ENG_IDLE;
        end
        ENG_WR_ARM:   if (card_ready) state_q <= ENG_WR_FETCH;
        ENG_WR_FETCH: state_q <= ENG_WR_DATA;
        ENG_WR_DATA: if (tx_fire) begin
          bcnt_q <= bcnt_q + BCNT_W'(1);
          if (last_byte)      state_q <= ENG_IDLE;
          else if (last_lane) state_q <= ENG_WR_FETCH;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);
endmodule

// File: rtl/sdw_host_regs.sv
module sdw_host_regs
  import sdw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned WORDS    = 128,
  parameter int unsigned SECTOR_W = 32,
  localparam int unsigned WIDX_W  = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  input  logic                host_we,
  output logic [WORD_W-1:0]   host_rdata,
  input  logic                eng_idle,
  input  logic                eng_done,
  input  logic [WORD_W-1:0]   ram_q,
  output logic                cache_we,
  output logic [WIDX_W-1:0]   cache_idx,
  output logic                load_go,
  output logic                flush_go,
  output logic [SECTOR_W-1:0] sector,
  input  logic                card_detect_n,
  input  logic                write_prot
);
  logic                hit_cache;
  logic                sector_we;
  logic [SECTOR_W-1:0] sector_q;
  logic                dirty_q;
  logic                cache_rd_q;
  logic [WORD_W-1:0]   reg_q, reg_mux;

  assign hit_cache = (host_addr[ADDR_W-1:WIDX_W+2] == '0);
  assign cache_idx = host_addr[WIDX_W+1:2];

  always_comb begin
    cache_we  = host_we && hit_cache && eng_idle;
    sector_we = host_we && eng_idle && (host_addr == ADDR_W'(MAP_SECTOR));
    load_go   = host_we && eng_idle && (host_addr == ADDR_W'(MAP_LOAD));
    flush_go  = host_we && eng_idle && (host_addr == ADDR_W'(MAP_FLUSH));
  end

  always_comb begin
    reg_mux = '0;
    if (host_addr == ADDR_W'(MAP_SECTOR))      reg_mux = WORD_W'(sector_q);
    else if (host_addr == ADDR_W'(MAP_DETECT)) reg_mux[0] = card_detect_n;
    else if (host_addr == ADDR_W'(MAP_WPROT))  reg_mux[0] = write_prot;
    else if (host_addr == ADDR_W'(MAP_READY))  reg_mux[0] = eng_idle;
    else if (host_addr == ADDR_W'(MAP_DIRTY))  reg_mux[0] = dirty_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sector_q   <= '0;
      dirty_q    <= 1'b0;
      cache_rd_q <= 1'b0;
      reg_q      <= '0;
    end else begin
      if (sector_we) sector_q <= host_wdata[SECTOR_W-1:0];
      if (eng_done)      dirty_q <= 1'b0;
      else if (cache_we) dirty_q <= 1'b1;
      cache_rd_q <= hit_cache && eng_idle;
      reg_q      <= reg_mux;
    end
  end

  assign host_rdata = cache_rd_q ? ram_q : reg_q;
  assign sector     = sector_q;

  assert_dirty_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !dirty_q);

  assert_dirty_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |=> dirty_q);

  assert_sector_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_idle |=> $stable(sector_q));
endmodule

// File: rtl/sd_sector_window.sv
module sd_sector_window
  import sdw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned WORDS    = 128,
  parameter int unsigned SECTOR_W = 32,
  localparam int unsigned WIDX_W  = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  input  logic                host_we,
  output logic [WORD_W-1:0]   host_rdata,
  input  logic                card_detect_n,
  input  logic                write_prot,
  input  logic                card_ready,
  output logic [SECTOR_W-1:0] card_sector,
  output logic                rd_start,
  output logic                wr_start,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [7:0]          rx_data,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [7:0]          tx_data
);
  logic              eng_idle, eng_done, load_go, flush_go;
  logic              h_we, e_we, p_we;
  logic [WIDX_W-1:0] h_idx, e_idx, p_idx;
  logic [WORD_W-1:0] e_wdata, p_wdata, ram_q;

  sdw_host_regs #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SECTOR_W(SECTOR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
    .host_rdata(host_rdata),
    .eng_idle(eng_idle), .eng_done(eng_done), .ram_q(ram_q),
    .cache_we(h_we), .cache_idx(h_idx),
    .load_go(load_go), .flush_go(flush_go),
    .sector(card_sector),
    .card_detect_n(card_detect_n), .write_prot(write_prot)
  );

  sdw_xfer_engine #(.WORDS(WORDS), .WORD_W(WORD_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .load_go(load_go), .flush_go(flush_go),
    .idle(eng_idle), .done(eng_done),
    .ram_addr(e_idx), .ram_we(e_we), .ram_wdata(e_wdata), .ram_q(ram_q),
    .card_ready(card_ready), .rd_start(rd_start), .wr_start(wr_start),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  // the engine owns the single port for the whole transfer
  always_comb begin
    if (eng_idle) begin
      p_idx = h_idx; p_we = h_we; p_wdata = host_wdata;
    end else begin
      p_idx = e_idx; p_we = e_we; p_wdata = e_wdata;
    end
  end

  sdw_cache_ram #(.DEPTH(WORDS), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .addr(p_idx), .we(p_we), .wdata(p_wdata), .q(ram_q)
  );

  assert_no_tx_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !tx_valid);
endmodule

// File: tb/sd_sector_window_tb_top.sv
`timescale 1ns/1ps
module sd_sector_window_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic        host_we = 0;
  logic [31:0] host_rdata;
  logic        card_detect_n = 0, write_prot = 0, card_ready = 1;
  logic [31:0] card_sector;
  logic        rd_start, wr_start, rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic [7:0]  rx_data = 0, tx_data;

  int total = 0, bad = 0, cyc = 0, rd_pulses = 0, wr_pulses = 0;
  logic [31:0] exp_cache [128];
  logic [7:0]  src_bytes [512];

  always #2.5 clk = ~clk;

  sd_sector_window dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .card_detect_n(card_detect_n),
    .write_prot(write_prot), .card_ready(card_ready), .card_sector(card_sector),
    .rd_start(rd_start), .wr_start(wr_start), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_start) rd_pulses <= rd_pulses + 1;
    if (wr_start) wr_pulses <= wr_pulses + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL R10 watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] pack4(input int w);
    return {src_bytes[4*w+3], src_bytes[4*w+2], src_bytes[4*w+1], src_bytes[4*w]};
  endfunction

  function automatic logic [7:0] cache_byte(input int i);
    logic [31:0] w = exp_cache[i/4];
    return w[8*(i%4) +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic host_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_we = 0;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic expect_read(input logic [15:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    host_read(a, d);
    check(d === e, req, d, e);
  endtask

  task automatic card_feed();
    for (int i = 0; i < 512;) begin
      @(negedge clk);
      rx_valid = ($urandom % 4) != 0;
      rx_data  = src_bytes[i];
      #1;
      if (rx_valid && rx_ready) i++;
    end
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic card_collect(output int errs);
    errs = 0;
    for (int i = 0; i < 512;) begin
      @(negedge clk);
      tx_ready = ($urandom % 3) != 0;
      #1;
      if (tx_valid && tx_ready) begin
        if (tx_data !== cache_byte(i)) begin
          errs++;
          $display("FAIL R4 byte %0d: actual=0x%0h expected=0x%0h", i, tx_data, cache_byte(i));
        end
        i++;
      end
    end
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    logic [31:0] d;
    int errs;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    check(!rd_start && !wr_start && !rx_ready && !tx_valid, "R10 outputs", {rd_start, wr_start, rx_ready, tx_valid}, 0);
    expect_read(16'h2010, 1, "R10 ready");
    expect_read(16'h2014, 0, "R10 dirty");
    expect_read(16'h1000, 0, "R10 sector");

    // R5 status passthrough
    card_detect_n = 1; write_prot = 0;
    expect_read(16'h2000, 1, "R5 detect");
    expect_read(16'h2004, 0, "R5 wprot");
    card_detect_n = 0; write_prot = 1;
    expect_read(16'h2000, 0, "R5 detect");
    expect_read(16'h2004, 1, "R5 wprot");

    // R9 unmapped reads
    expect_read(16'h0200, 0, "R9 unmapped");
    expect_read(16'h1010, 0, "R9 unmapped");
    expect_read(16'h2008, 0, "R9 unmapped");
    expect_read(16'hF3C4, 0, "R9 unmapped");

    // R2 sector register
    host_write(16'h1000, 32'h10);
    expect_read(16'h1000, 32'h10, "R2 readback");
    check(card_sector === 32'h10, "R2 card_sector", card_sector, 32'h10);

    // R1 and R7: fill cache from host
    for (int k = 0; k < 128; k++) begin
      exp_cache[k] = $urandom;
      host_write(16'(4*k) | 16'($urandom % 4), exp_cache[k]);
    end
    expect_read(16'h2014, 1, "R7 dirty set");
    errs = 0;
    for (int k = 127; k >= 0; k--) begin
      host_read(16'(4*k), d);
      if (d !== exp_cache[k]) begin
        errs++;
        $display("FAIL R1 word %0d: actual=0x%0h expected=0x%0h", k, d, exp_cache[k]);
      end
    end
    check(errs == 0, "R1 cache readback", errs, 0);

    // R4 flush, holding the controller busy first
    card_ready = 0;
    host_write(16'h1008, 32'h1);
    repeat (3) @(negedge clk);
    check(wr_pulses == 0, "R4 start waits", wr_pulses, 0);
    expect_read(16'h2010, 0, "R6 busy");
    expect_read(16'h0000, 0, "R9 cache blocked");
    // R8 writes during transfer are ignored
    host_write(16'h1004, 32'h1);
    host_write(16'h1000, 32'h55);
    host_write(16'h0000, 32'hFFFF_FFFF);
    card_ready = 1;
    card_collect(errs);
    check(errs == 0, "R4 stream bytes", errs, 0);
    check(wr_pulses == 1, "R4 one pulse", wr_pulses, 1);
    check(rd_pulses == 0 && !rx_ready, "R8 load ignored", rd_pulses, 0);
    expect_read(16'h2010, 1, "R6 ready after flush");
    expect_read(16'h2014, 0, "R7 cleared by flush");
    expect_read(16'h1000, 32'h10, "R8 sector kept");
    expect_read(16'h0000, exp_cache[0], "R8 cache kept");

    // R3 load after a fresh dirtying write
    host_write(16'h0040, 32'hA5A5_5A5A);
    expect_read(16'h2014, 1, "R7 dirty set again");
    for (int i = 0; i < 512; i++) src_bytes[i] = 8'($urandom);
    host_write(16'h1004, 32'h0);
    expect_read(16'h2010, 0, "R6 busy load");
    card_feed();
    check(rd_pulses == 1, "R3 one pulse", rd_pulses, 1);
    check(!tx_valid, "R3 no transmit", tx_valid, 0);
    expect_read(16'h2010, 1, "R6 ready after load");
    expect_read(16'h2014, 0, "R7 cleared by load");
    errs = 0;
    for (int k = 0; k < 128; k++) begin
      exp_cache[k] = pack4(k);
      host_read(16'(4*k), d);
      if (d !== exp_cache[k]) begin
        errs++;
        $display("FAIL R3 word %0d: actual=0x%0h expected=0x%0h", k, d, exp_cache[k]);
      end
    end
    check(errs == 0, "R3 packing", errs, 0);

    // R4 flush of the loaded sector, directed word 0 byte order
    check(exp_cache[0][7:0] === src_bytes[0], "R3 low lane", exp_cache[0][7:0], src_bytes[0]);
    host_write(16'h1008, 32'h0);
    card_collect(errs);
    check(errs == 0, "R4 loaded stream", errs, 0);
    check(wr_pulses == 2, "R4 second pulse", wr_pulses, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule